// File: doc/BRIEF.md
# Oversampling Serial Receiver with Status FIFO

This block receives asynchronous serial characters from a single input line. An external baud tick runs at sixteen times the bit rate, or at eight times the bit rate when double-speed mode is selected. The receiver waits for a high-to-low transition on the line, which marks the start bit. It takes its bit timing from that edge. It then decides each bit by voting on three samples taken in the middle of the bit.

Each completed character goes into a two-entry receive FIFO. The character carries its own parity-error, frame-error and overrun flags. A consumer sees the oldest character and its flags at the read port, and pulses a read strobe to discard it. Clearing the enable stops reception at once, drops any partial frame and empties the FIFO.

Top module: `uart_rx_buf`

## Requirements
- R1: After reset, `rx_valid_o`, `par_err_o`, `frm_err_o` and `ovr_o` are all low.
- R2: A frame is one low start bit, then the data bits least significant bit first, then an optional parity bit, then a stop bit. Such a frame with 8 data bits and no parity produces the transmitted byte on `rx_data_o`.
- R3: `width_i` selects 5, 6, 7 or 8 data bits for the codes 0, 1, 2 and 3. Bits of `rx_data_o` above the selected width read as zero.
- R4: `par_mode_i` selects the parity. 2'b10 is even and 2'b11 is odd. 2'b00 and 2'b01 mean no parity bit is sent or checked. `par_err_o` is high for a character whose parity bit did not match, and only when parity was enabled.
- R5: `frm_err_o` is high for a character whose stop bit was decided low.
- R6: Each bit is the majority of three samples around its centre: samples 8, 9 and 10 of 16, or 4, 5 and 6 of 8. An inverted glitch that lasts one tick inside a bit does not change the received value.
- R7: A low pulse that has ended before the start bit is voted is treated as a false start. No character is produced, and the next proper frame is received correctly.
- R8: With `dbl_i` high, one bit lasts 8 ticks instead of 16.
- R9: `rx_valid_o` stays high while any unread character remains. Characters are presented oldest first. The head character stays stable until `rd_i` is pulsed. The FIFO holds two characters.
- R10: If a character completes while the FIFO is full and no read happens in that cycle, the character is dropped. The newest stored character then has `ovr_o` set when it reaches the head.
- R11: While `en_i` is low, the FIFO is empty from the next cycle on. A frame that was in progress when `en_i` dropped produces no character.
- R12: If a character completes in the same cycle as a read of a full FIFO, the character is stored and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial input line, idles high |
| tick_i | input | 1 | Oversampling tick, one cycle wide |
| en_i | input | 1 | Receiver enable; low aborts reception and flushes the FIFO |
| dbl_i | input | 1 | Double-speed mode (8 ticks per bit) |
| par_mode_i | input | 2 | Parity select: 2'b10 even, 2'b11 odd, otherwise none |
| width_i | input | 2 | Data width code: 0..3 selects 5..8 bits |
| rd_i | input | 1 | Read strobe; discards the head character |
| rx_valid_o | output | 1 | At least one unread character is present |
| rx_data_o | output | 8 | Head character, right-aligned |
| par_err_o | output | 1 | Parity error of the head character |
| frm_err_o | output | 1 | Frame error of the head character |
| ovr_o | output | 1 | Overrun was recorded on the head character |

## Verification
A character that completes in the very cycle a full FIFO is read is the collision case: push and pop land together, and a wrong decision either drops the character or raises a false overrun. The bench first sends a reference frame into an empty FIFO, aligned to a fixed tick phase, and counts the clock edges until `rx_valid_o` rises. It then fills the FIFO and replays the same frame from the same phase, pulsing `rd_i` over exactly that edge. It judges the outcome by reading out the two remaining characters and checking their order, their data and that neither has the overrun flag.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int unsigned CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              pe;
    logic              fe;
    logic              ovr;
  } rx_char_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic       dbl_i,
  input  logic [1:0] par_mode_i,
  input  logic [1:0] width_i,
  output logic       push_o,
  output rx_char_t   char_o
);
  localparam int unsigned CNT_W = $clog2(OSR + 1);
  localparam logic [CNT_W-1:0] LAST_N = CNT_W'(OSR);
  localparam logic [CNT_W-1:0] LAST_D = CNT_W'(OSR / 2);
  localparam logic [CNT_W-1:0] MID_N  = CNT_W'(OSR / 2);
  localparam logic [CNT_W-1:0] MID_D  = CNT_W'(OSR / 4);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q, idx, n_last, n_mid;
  logic [2:0]        bit_q;
  logic [CHAR_W-1:0] sh_q;
  logic              acc_q, s_a_q, s_b_q, prev_q, vote, last_data, par_en;

  assign n_last    = dbl_i ? LAST_D : LAST_N;
  assign n_mid     = dbl_i ? MID_D : MID_N;
  assign idx       = (cnt_q >= n_last) ? CNT_W'(1) : cnt_q + CNT_W'(1);
  assign vote      = (s_a_q & s_b_q) | (s_a_q & rxd_i) | (s_b_q & rxd_i);
  assign last_data = (bit_q == 3'(width_i) + 3'd4);
  assign par_en    = par_mode_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      acc_q   <= 1'b0;
      s_a_q   <= 1'b1;
      s_b_q   <= 1'b1;
      prev_q  <= 1'b1;
      push_o  <= 1'b0;
      char_o  <= '0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      prev_q  <= 1'b1;
      push_o  <= 1'b0;
    end else begin
      push_o <= 1'b0;
      if (tick_i) begin
        prev_q <= rxd_i;
        if (state_q == ST_IDLE) begin
          // start hunt: needs a high sample followed by a low one
          if (prev_q && !rxd_i) begin
            state_q <= ST_START;
            cnt_q   <= CNT_W'(1);
            acc_q   <= 1'b0;
          end
        end else begin
          cnt_q <= idx;
          if (idx == n_mid)               s_a_q <= rxd_i;
          if (idx == n_mid + CNT_W'(1))   s_b_q <= rxd_i;
          if (idx == n_mid + CNT_W'(2)) begin
            unique case (state_q)
              ST_START: if (vote) state_q <= ST_IDLE;
              ST_DATA: begin
                sh_q  <= {vote, sh_q[CHAR_W-1:1]};
                acc_q <= acc_q ^ vote;
              end
              ST_PAR:  acc_q <= acc_q ^ vote;
              ST_STOP: begin
                push_o      <= 1'b1;
                char_o.data <= sh_q >> (3'd3 - 3'(width_i));
                char_o.pe   <= par_en & (acc_q ^ par_mode_i[0]);
                char_o.fe   <= ~vote;
                char_o.ovr  <= 1'b0;
                state_q     <= ST_IDLE;
              end
              default: ;
            endcase
          end
          if (idx == n_last) begin
            unique case (state_q)
              ST_START: begin
                state_q <= ST_DATA;
                bit_q   <= '0;
              end
              ST_DATA: begin
                if (last_data) state_q <= par_en ? ST_PAR : ST_STOP;
                else           bit_q   <= bit_q + 3'd1;
              end
              ST_PAR:  state_q <= ST_STOP;
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter  int unsigned DEPTH = 2,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  rx_char_t         wdata_i,
  input  logic             pop_i,
  output logic             valid_o,
  output rx_char_t         head_o,
  output logic [CNT_W-1:0] fill_o
);
  rx_char_t         mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q, young;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop, do_push, ovr_set;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign do_pop  = pop_i && (cnt_q != '0);
  assign do_push = push_i && ((cnt_q != CNT_W'(DEPTH)) || do_pop);
  assign ovr_set = push_i && !do_push;
  assign young   = (wr_q == '0) ? PTR_W'(DEPTH - 1) : wr_q - PTR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= wdata_i;
        wr_q        <= nxt(wr_q);
      end
      if (ovr_set) mem_q[young].ovr <= 1'b1;
      if (do_pop)  rd_q <= nxt(rd_q);
      unique case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: ;
      endcase
    end
  end

  assign valid_o = (cnt_q != '0);
  assign head_o  = mem_q[rd_q];
  assign fill_o  = cnt_q;
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned DEPTH       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rxd_i,
  input  logic        tick_i,
  input  logic        en_i,
  input  logic        dbl_i,
  input  logic [1:0]  par_mode_i,
  input  logic [1:0]  width_i,
  input  logic        rd_i,
  output logic        rx_valid_o,
  output logic [7:0]  rx_data_o,
  output logic        par_err_o,
  output logic        frm_err_o,
  output logic        ovr_o
);
  localparam int unsigned FILL_W = $clog2(DEPTH + 1);

  logic              rxd_s, frm_push;
  rx_char_t          frm_char, head;
  logic [FILL_W-1:0] fifo_fill;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  uart_rx_frame #(.OSR(OSR)) frame_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .tick_i    (tick_i),
    .rxd_i     (rxd_s),
    .dbl_i     (dbl_i),
    .par_mode_i(par_mode_i),
    .width_i   (width_i),
    .push_o    (frm_push),
    .char_o    (frm_char)
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(!en_i),
    .push_i (frm_push),
    .wdata_i(frm_char),
    .pop_i  (rd_i),
    .valid_o(rx_valid_o),
    .head_o (head),
    .fill_o (fifo_fill)
  );

  assign rx_data_o = head.data;
  assign par_err_o = rx_valid_o & head.pe;
  assign frm_err_o = rx_valid_o & head.fe;
  assign ovr_o     = rx_valid_o & head.ovr;
endmodule

// File: rtl/uart_rx_buf_chk.sv
module uart_rx_buf_chk #(
  parameter int unsigned DEPTH  = 2,
  parameter int unsigned FILL_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              rd_i,
  input logic              rx_valid_o,
  input logic [7:0]        rx_data_o,
  input logic [FILL_W-1:0] fifo_fill
);
  // R11
  disable_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !rx_valid_o);

  // R9
  unread_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rd_i && en_i) |=> rx_valid_o);

  // R9
  head_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rd_i && en_i) |=> $stable(rx_data_o));

  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_fill <= FILL_W'(DEPTH));

  // R11
  empty_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (fifo_fill == '0));
endmodule

bind uart_rx_buf uart_rx_buf_chk #(
  .DEPTH (DEPTH),
  .FILL_W($clog2(DEPTH + 1))
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .rd_i      (rd_i),
  .rx_valid_o(rx_valid_o),
  .rx_data_o (rx_data_o),
  .fifo_fill (fifo_fill)
);

// File: tb/uart_rx_buf_tb.sv
module uart_rx_buf_tb_top;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       en = 1'b1;
  logic       dbl = 1'b0;
  logic [1:0] pmode = 2'b00;
  logic [1:0] wcode = 2'b11;
  logic       rd = 1'b0;
  logic       tick;
  logic       rx_valid, par_err, frm_err, ovr;
  logic [7:0] rx_data;
  int         phase = 0;
  int         total = 0;
  int         bad = 0;

  always #5 clk = ~clk;

  initial forever begin
    @(posedge clk);
    phase <= (phase + 1) % DIV;
  end
  assign tick = (phase == 0);

  uart_rx_buf dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .tick_i(tick), .en_i(en),
    .dbl_i(dbl), .par_mode_i(pmode), .width_i(wcode), .rd_i(rd),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .par_err_o(par_err),
    .frm_err_o(frm_err), .ovr_o(ovr)
  );

  // {flip_par, stop, dbl, pmode, wcode, data}
  localparam logic [14:0] VEC [8] = '{
    {1'b0, 1'b1, 1'b0, 2'b00, 2'b11, 8'hA5},
    {1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 8'h3C},
    {1'b0, 1'b1, 1'b0, 2'b01, 2'b10, 8'hDA},
    {1'b0, 1'b1, 1'b0, 2'b10, 2'b11, 8'hC3},
    {1'b1, 1'b1, 1'b0, 2'b11, 2'b11, 8'h81},
    {1'b0, 1'b0, 1'b0, 2'b00, 2'b11, 8'h7E},
    {1'b0, 1'b1, 1'b1, 2'b10, 2'b11, 8'h96},
    {1'b1, 1'b0, 1'b1, 2'b11, 2'b01, 8'h0F}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic align();
    @(negedge clk);
    while (phase != 0) @(negedge clk);
  endtask

  task automatic drive_bit(input logic b, input logic g, input int bp);
    for (int c = 0; c < bp; c++) begin
      rxd = (g && c >= 38 && c < 42) ? ~b : b;
      @(negedge clk);
    end
  endtask

  // caller aligns first; ends after the stop bit plus one idle bit
  task automatic send_raw(input logic [7:0] d, input int nb, input logic [1:0] pm,
                          input logic dm, input logic stop_b, input logic flip, input int gbit);
    int bp;
    logic [7:0] m;
    bp = (dm ? 8 : 16) * DIV;
    m  = d & 8'((1 << nb) - 1);
    drive_bit(1'b0, 1'b0, bp);
    for (int i = 0; i < nb; i++) drive_bit(d[i], gbit == i, bp);
    if (pm[1]) drive_bit((^m) ^ pm[0] ^ flip, 1'b0, bp);
    drive_bit(stop_b, 1'b0, bp);
    drive_bit(1'b1, 1'b0, bp);
  endtask

  task automatic send8(input logic [7:0] d);
    align();
    send_raw(d, 8, 2'b00, 1'b0, 1'b1, 1'b0, -1);
  endtask

  task automatic pop();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_char(input string req, input logic [7:0] d, input logic pe,
                             input logic fe, input logic ov);
    chk(req, rx_valid, 1);
    chk(req, rx_data, d);
    chk(req, {par_err, frm_err, ovr}, {pe, fe, ov});
    pop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {rx_valid, par_err, frm_err, ovr}, 4'b0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {rx_valid, par_err, frm_err, ovr}, 4'b0000);

    // vector walk: R2 R3 R4 R5 R8
    for (int i = 0; i < 8; i++) begin
      logic [14:0] v;
      string req;
      int nb;
      v = VEC[i];
      case (i)
        0:       req = "R2";
        1, 2:    req = "R3";
        3, 4:    req = "R4";
        5:       req = "R5";
        default: req = "R8";
      endcase
      dbl   = v[12];
      pmode = v[11:10];
      wcode = v[9:8];
      nb    = int'(v[9:8]) + 5;
      align();
      send_raw(v[7:0], nb, v[11:10], v[12], v[13], v[14], -1);
      expect_char(req, v[7:0] & 8'((1 << nb) - 1), v[11] & v[14], ~v[13], 1'b0);
    end
    dbl = 1'b0; pmode = 2'b00; wcode = 2'b11;

    // R6 single-tick glitches inside the sampling window
    align();
    send_raw(8'hFF, 8, 2'b00, 1'b0, 1'b1, 1'b0, 3);
    expect_char("R6", 8'hFF, 0, 0, 0);
    align();
    send_raw(8'h00, 8, 2'b00, 1'b0, 1'b1, 1'b0, 5);
    expect_char("R6", 8'h00, 0, 0, 0);

    // R7 short low pulse is a false start
    align();
    rxd = 1'b0;
    repeat (4 * DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (32 * DIV) @(negedge clk);
    chk("R7", rx_valid, 0);
    send8(8'h4D);
    expect_char("R7", 8'h4D, 0, 0, 0);

    // R9 two characters held in order
    send8(8'h11);
    send8(8'h22);
    chk("R9", rx_valid, 1);
    expect_char("R9", 8'h11, 0, 0, 0);
    chk("R9", rx_valid, 1);
    expect_char("R9", 8'h22, 0, 0, 0);
    chk("R9", rx_valid, 0);

    // R10 third character dropped, overrun on newest
    send8(8'h31);
    send8(8'h32);
    send8(8'h33);
    expect_char("R10", 8'h31, 0, 0, 0);
    expect_char("R10", 8'h32, 0, 0, 1);
    chk("R10", rx_valid, 0);

    // R11 disable flushes stored characters
    send8(8'h5C);
    chk("R11", rx_valid, 1);
    en = 1'b0;
    @(negedge clk);
    chk("R11", rx_valid, 0);
    en = 1'b1;
    @(negedge clk);
    chk("R11", rx_valid, 0);

    // R11 disable mid-frame discards it
    align();
    fork
      send_raw(8'h00, 8, 2'b00, 1'b0, 1'b1, 1'b0, -1);
      begin
        repeat (3 * 16 * DIV) @(negedge clk);
        en = 1'b0;
      end
    join
    repeat (16 * DIV) @(negedge clk);
    en = 1'b1;
    repeat (32 * DIV) @(negedge clk);
    chk("R11", rx_valid, 0);
    send8(8'h6B);
    expect_char("R11", 8'h6B, 0, 0, 0);

    // R12 measure completion edge, then collide a read with it
    n = 0;
    align();
    fork
      send_raw(8'h77, 8, 2'b00, 1'b0, 1'b1, 1'b0, -1);
      while (!rx_valid) begin
        @(negedge clk);
        n++;
      end
    join
    expect_char("R12", 8'h77, 0, 0, 0);
    send8(8'h71);
    send8(8'h72);
    align();
    fork
      send_raw(8'h77, 8, 2'b00, 1'b0, 1'b1, 1'b0, -1);
      begin
        repeat (n - 1) @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
      end
    join
    expect_char("R12", 8'h72, 0, 0, 0);
    expect_char("R12", 8'h77, 0, 0, 0);
    chk("R12", rx_valid, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule